// File: doc/BRIEF.md
# Serial Control Word Loader

This block receives 24-bit control words on a three-wire serial port (a shift clock, a data line and a load strobe) and distributes them to a small bank of parallel configuration latches. All three serial lines are asynchronous to the fast system clock. Each one passes through a multi-stage synchronizer, and edges are found on the synchronized copies.

Bits enter most-significant first on each rising edge of the serial clock. The last two bits shifted are a destination code. A rising edge on the load strobe copies the 22 payload bits of the current shift register into the latch that the code selects. Code 00 selects the reference-divider latch, code 01 the N-divider latch and code 10 the function latch. Code 11 is an initialisation load: it writes the function latch and also sends a counter-reset pulse.

Each latch is shown in full on its own output. The reference divide value and the function fields are also decoded onto ports of their own. Every update raises a one-cycle strobe for the latch that was written.

Top module: `serial_latch_port`

## Requirements
- R1: After reset all latch outputs, decoded fields and strobes are zero.
- R2: Each rising edge of `ser_clk` shifts the synchronized `ser_data` into bit 0 of a 24-bit register and moves the older bits up, so the first bit sent ends in bit 23. Changes of `ser_data` with no `ser_clk` rising edge shift nothing.
- R3: On a `ser_le` rising edge with code bits [1:0] = 00, `ref_word` takes word bits [23:2], and `ref_div` shows word bits [15:2].
- R4: On a `ser_le` rising edge with code 01, `ncnt_word` takes word bits [23:2].
- R5: On a `ser_le` rising edge with code 10, `func_word` takes word bits [23:2]. The decoded fields are: `fn_cp_tristate` = word bit 4, `fn_mux_sel` = word bits [7:5], `fn_cur1` = word bits [15:13], `fn_cur2` = word bits [18:16].
- R6: Code 11 loads `func_word` in the same way as code 10 and pulses `cnt_reset`. `ref_word` and `ncnt_word` are left unchanged.
- R7: Each load raises exactly one single-cycle strobe among `ref_load`, `ncnt_load` and `func_load`, namely the one for the written latch. `cnt_reset` pulses for one cycle together with `func_load` on an initialisation load.
- R8: No latch output changes unless a `ser_le` rising edge occurs, however many bits are shifted.
- R9: A `ser_le` rising edge after fewer than 24 new bits loads whatever the register currently holds. The count of bits shifted since the last load restarts at every load and never exceeds 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Asynchronous serial shift clock |
| ser_data | input | 1 | Asynchronous serial data, MSB first |
| ser_le | input | 1 | Asynchronous load strobe |
| ref_word | output | 22 | Reference-divider latch payload |
| ncnt_word | output | 22 | N-divider latch payload |
| func_word | output | 22 | Function latch payload |
| ref_div | output | 14 | Reference divide value |
| fn_mux_sel | output | 3 | Output-multiplexer select field |
| fn_cur1 | output | 3 | Charge-pump current setting 1 |
| fn_cur2 | output | 3 | Charge-pump current setting 2 |
| fn_cp_tristate | output | 1 | Charge-pump three-state control |
| ref_load | output | 1 | One-cycle update strobe, reference latch |
| ncnt_load | output | 1 | One-cycle update strobe, N latch |
| func_load | output | 1 | One-cycle update strobe, function latch |
| cnt_reset | output | 1 | One-cycle counter reset on initialisation load |

## Verification
The strobe assertions rely on the serial lines changing slowly compared with the system clock. Each level must hold for several cycles, so that no two load edges are seen on adjacent cycles and no shift edge lands in the same cycle as a load edge. The stimulus holds every level of `ser_clk`, `ser_data` and `ser_le` for at least three system cycles. It changes `ser_data` only while `ser_clk` is low and settled. It raises `ser_le` only after the serial clock has returned low.

// File: rtl/slp_pkg.sv
package slp_pkg;

   // destination code carried in the two trailing bits of each word
   localparam int unsigned SLP_SEL_W = 2;

   typedef enum logic [SLP_SEL_W-1:0] {
      SEL_REF  = 2'b00,
      SEL_NCNT = 2'b01,
      SEL_FUNC = 2'b10,
      SEL_INIT = 2'b11
   } slp_sel_e;

   // function-latch field positions, counted inside the payload (word bit - 2)
   localparam int unsigned FN_TRI_POS  = 2;
   localparam int unsigned FN_MUX_LSB  = 3;
   localparam int unsigned FN_CUR1_LSB = 11;
   localparam int unsigned FN_CUR2_LSB = 14;
   localparam int unsigned FN_FIELD_W  = 3;

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("slp_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("slp_sync: WIDTH must be at least 1");
      end
   endgenerate

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], async_in[b]};
         end
         assign sync_out[b] = chain[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/slp_shift.sv
module slp_shift #(
   parameter int unsigned WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   input  logic              clear_cnt,
   output logic [WORD_W-1:0] word_out
);

   localparam int unsigned CNT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  bits_seen;

   generate
      if (WORD_W < 4) begin : g_bad_word
         $error("slp_shift: WORD_W too small");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sh_q <= '0;
      else if (shift_en) sh_q <= {sh_q[WORD_W-2:0], bit_in};
   end

   // bits shifted since the previous load, saturating at a full word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              bits_seen <= '0;
      else if (clear_cnt)                      bits_seen <= '0;
      else if (shift_en && bits_seen < CNT_MAX) bits_seen <= bits_seen + 1'b1;
   end

   assign word_out = sh_q;

   AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sh_q) |-> $past(shift_en)); // R2
   AST_SHIFT_TAKES_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> sh_q[0] == $past(bit_in)); // R2
   AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      bits_seen <= CNT_MAX); // R9
   AST_BITCNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear_cnt |=> bits_seen == '0); // R9

endmodule

// File: rtl/slp_latch_bank.sv
module slp_latch_bank
   import slp_pkg::*;
#(
   parameter int unsigned WORD_W = 24
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_en,
   input  logic [WORD_W-1:0]           word_in,
   output logic [WORD_W-SLP_SEL_W-1:0] ref_q,
   output logic [WORD_W-SLP_SEL_W-1:0] ncnt_q,
   output logic [WORD_W-SLP_SEL_W-1:0] func_q,
   output logic                        ref_stb,
   output logic                        ncnt_stb,
   output logic                        func_stb,
   output logic                        init_stb
);

   localparam int unsigned PAY_W = WORD_W - SLP_SEL_W;

   slp_sel_e         sel;
   logic [PAY_W-1:0] payload;
   logic             wr_ref, wr_ncnt, wr_func, wr_init;

   assign sel     = slp_sel_e'(word_in[SLP_SEL_W-1:0]);
   assign payload = word_in[WORD_W-1:SLP_SEL_W];

   always_comb begin
      wr_ref  = 1'b0;
      wr_ncnt = 1'b0;
      wr_func = 1'b0;
      wr_init = 1'b0;
      if (load_en) begin
         unique case (sel)
            SEL_REF:  wr_ref  = 1'b1;
            SEL_NCNT: wr_ncnt = 1'b1;
            SEL_FUNC: wr_func = 1'b1;
            SEL_INIT: begin
               wr_func = 1'b1;
               wr_init = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q  <= '0;
         ncnt_q <= '0;
         func_q <= '0;
      end else begin
         if (wr_ref)  ref_q  <= payload;
         if (wr_ncnt) ncnt_q <= payload;
         if (wr_func) func_q <= payload;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_stb  <= 1'b0;
         ncnt_stb <= 1'b0;
         func_stb <= 1'b0;
         init_stb <= 1'b0;
      end else begin
         ref_stb  <= wr_ref;
         ncnt_stb <= wr_ncnt;
         func_stb <= wr_func;
         init_stb <= wr_init;
      end
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ref_stb, ncnt_stb, func_stb})); // R7
   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_stb || ncnt_stb || func_stb) |=> !(ref_stb || ncnt_stb || func_stb)); // R7
   AST_INIT_WITH_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
      init_stb |-> func_stb); // R6
   AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ref_q) |-> ref_stb); // R8
   AST_NCNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ncnt_q) |-> ncnt_stb); // R8
   AST_FUNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(func_q) |-> func_stb); // R8

endmodule

// File: rtl/serial_latch_port.sv
module serial_latch_port
   import slp_pkg::*;
#(
   parameter int unsigned WORD_W      = 24,
   parameter int unsigned REF_W       = 14,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned PAY_W      = WORD_W - SLP_SEL_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ser_clk,
   input  logic                  ser_data,
   input  logic                  ser_le,
   output logic [PAY_W-1:0]      ref_word,
   output logic [PAY_W-1:0]      ncnt_word,
   output logic [PAY_W-1:0]      func_word,
   output logic [REF_W-1:0]      ref_div,
   output logic [FN_FIELD_W-1:0] fn_mux_sel,
   output logic [FN_FIELD_W-1:0] fn_cur1,
   output logic [FN_FIELD_W-1:0] fn_cur2,
   output logic                  fn_cp_tristate,
   output logic                  ref_load,
   output logic                  ncnt_load,
   output logic                  func_load,
   output logic                  cnt_reset
);

   localparam int unsigned IDX_DATA = 0;
   localparam int unsigned IDX_CLK  = 1;
   localparam int unsigned IDX_LE   = 2;

   generate
      if (PAY_W < REF_W) begin : g_bad_ref
         $error("serial_latch_port: reference field wider than payload");
      end
      if (PAY_W < FN_CUR2_LSB + FN_FIELD_W) begin : g_bad_fn
         $error("serial_latch_port: function fields exceed payload");
      end
   endgenerate

   logic [2:0]        pins_sync;
   logic              ck_prev, le_prev;
   logic              ck_rise, le_rise;
   logic [WORD_W-1:0] shifted;

   slp_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in ({ser_le, ser_clk, ser_data}),
      .sync_out (pins_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ck_prev <= 1'b0;
         le_prev <= 1'b0;
      end else begin
         ck_prev <= pins_sync[IDX_CLK];
         le_prev <= pins_sync[IDX_LE];
      end
   end

   assign ck_rise = pins_sync[IDX_CLK] & ~ck_prev;
   assign le_rise = pins_sync[IDX_LE]  & ~le_prev;

   slp_shift #(.WORD_W(WORD_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (ck_rise),
      .bit_in    (pins_sync[IDX_DATA]),
      .clear_cnt (le_rise),
      .word_out  (shifted)
   );

   slp_latch_bank #(.WORD_W(WORD_W)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (le_rise),
      .word_in  (shifted),
      .ref_q    (ref_word),
      .ncnt_q   (ncnt_word),
      .func_q   (func_word),
      .ref_stb  (ref_load),
      .ncnt_stb (ncnt_load),
      .func_stb (func_load),
      .init_stb (cnt_reset)
   );

   assign ref_div        = ref_word[REF_W-1:0];
   assign fn_cp_tristate = func_word[FN_TRI_POS];
   assign fn_mux_sel     = func_word[FN_MUX_LSB  +: FN_FIELD_W];
   assign fn_cur1        = func_word[FN_CUR1_LSB +: FN_FIELD_W];
   assign fn_cur2        = func_word[FN_CUR2_LSB +: FN_FIELD_W];

   AST_LOAD_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_load || ncnt_load || func_load) |-> $past(le_rise)); // R8

endmodule

// File: tb/serial_latch_port_bench.sv
module serial_latch_port_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_data = 1'b0;
   logic ser_le = 1'b0;

   logic [21:0] ref_word, ncnt_word, func_word;
   logic [13:0] ref_div;
   logic [2:0]  fn_mux_sel, fn_cur1, fn_cur2;
   logic        fn_cp_tristate, ref_load, ncnt_load, func_load, cnt_reset;

   int checks = 0;
   int failures = 0;
   int n_ref = 0, n_ncnt = 0, n_func = 0, n_init = 0;
   int e_ref = 0, e_ncnt = 0, e_func = 0, e_init = 0;
   logic [23:0] m_sh = '0;
   logic [21:0] m_ref = '0, m_ncnt = '0, m_func = '0;

   always #10 clk = ~clk;

   serial_latch_port u_serial_latch_port (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
      .ref_word(ref_word), .ncnt_word(ncnt_word), .func_word(func_word), .ref_div(ref_div),
      .fn_mux_sel(fn_mux_sel), .fn_cur1(fn_cur1), .fn_cur2(fn_cur2),
      .fn_cp_tristate(fn_cp_tristate), .ref_load(ref_load), .ncnt_load(ncnt_load),
      .func_load(func_load), .cnt_reset(cnt_reset)
   );

   // count strobe-high cycles; a strobe longer than one cycle counts twice (R7)
   always @(posedge clk) begin
      if (rst_n) begin
         if (ref_load)  n_ref++;
         if (ncnt_load) n_ncnt++;
         if (func_load) n_func++;
         if (cnt_reset) n_init++;
      end
   end

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic shift_bits(input logic [23:0] v, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_data = v[i];
         tick(3);
         ser_clk = 1'b1;
         tick(4);
         ser_clk = 1'b0;
         tick(3);
         m_sh = {m_sh[22:0], v[i]};
      end
   endtask

   task automatic pulse_le();
      logic [1:0] code;
      code = m_sh[1:0];
      ser_le = 1'b1;
      tick(4);
      ser_le = 1'b0;
      tick(6);
      case (code)
         2'b00: begin m_ref = m_sh[23:2]; e_ref++; end
         2'b01: begin m_ncnt = m_sh[23:2]; e_ncnt++; end
         2'b10: begin m_func = m_sh[23:2]; e_func++; end
         default: begin m_func = m_sh[23:2]; e_func++; e_init++; end
      endcase
   endtask

   task automatic check_all(input string tag);
      chk(tag, "ref_word", 32'(ref_word), 32'(m_ref));
      chk(tag, "ncnt_word", 32'(ncnt_word), 32'(m_ncnt));
      chk(tag, "func_word", 32'(func_word), 32'(m_func));
      chk(tag, "ref_div", 32'(ref_div), 32'(m_ref[13:0]));
      chk(tag, "fn_cp_tristate", 32'(fn_cp_tristate), 32'(m_func[2]));
      chk(tag, "fn_mux_sel", 32'(fn_mux_sel), 32'(m_func[5:3]));
      chk(tag, "fn_cur1", 32'(fn_cur1), 32'(m_func[13:11]));
      chk(tag, "fn_cur2", 32'(fn_cur2), 32'(m_func[16:14]));
      chk({tag, "/R7"}, "ref_load pulses", 32'(n_ref), 32'(e_ref));
      chk({tag, "/R7"}, "ncnt_load pulses", 32'(n_ncnt), 32'(e_ncnt));
      chk({tag, "/R7"}, "func_load pulses", 32'(n_func), 32'(e_func));
      chk({tag, "/R6"}, "cnt_reset pulses", 32'(n_init), 32'(e_init));
   endtask

   task automatic t_reset();
      chk("R1", "ref_load", 32'(ref_load), 0);
      chk("R1", "ncnt_load", 32'(ncnt_load), 0);
      chk("R1", "func_load", 32'(func_load), 0);
      chk("R1", "cnt_reset", 32'(cnt_reset), 0);
      check_all("R1");
   endtask

   task automatic t_ref_load();
      shift_bits(24'hA53C7C, 24);
      pulse_le();
      chk("R2", "ref_word msb-first", 32'(ref_word), 32'(22'(24'hA53C7C >> 2)));
      check_all("R3");
   endtask

   task automatic t_ncnt_load();
      shift_bits(24'h5F0E31, 24);
      pulse_le();
      check_all("R4");
   endtask

   task automatic t_func_load();
      shift_bits(24'h3B6A9E, 24);
      pulse_le();
      chk("R5", "fn_mux_sel literal", 32'(fn_mux_sel), 32'(3'(24'h3B6A9E >> 5)));
      check_all("R5");
   endtask

   task automatic t_init_load();
      shift_bits(24'h92D4F7, 24);
      pulse_le();
      check_all("R6");
   endtask

   task automatic t_no_load();
      shift_bits(24'hFFFFFF, 24);
      tick(10);
      check_all("R8");
   endtask

   task automatic t_short_word();
      shift_bits(24'h000016, 5);
      pulse_le();
      check_all("R9");
      shift_bits(24'h000000, 3);
      pulse_le();
      check_all("R9");
   endtask

   task automatic t_data_wiggle();
      shift_bits(24'h1234C8, 24);
      for (int k = 0; k < 6; k++) begin
         ser_data = ~ser_data;
         tick(3);
      end
      pulse_le();
      check_all("R2");
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_ref_load();
      t_ncnt_load();
      t_func_load();
      t_init_load();
      t_no_load();
      t_short_word();
      t_data_wiggle();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule